// File: doc/BRIEF.md
# Programmable Highest-Priority Resolver

This block picks one winner per interrupt class from up to 40 sources. The ordering comes from a table of 40 programmable priority slots, not from the source numbers. Each slot names a source ID and has its own valid flag. A source competes only if it is both pending and enabled. Its class-select bit decides whether it competes for the fast (FIQ) result or the normal (IRQ) result.

Both winners come out together in a single 32-bit status word. Each class has a valid flag and an ID field, and the ID field reads 0x3F when that class has no winner. The word is combinational from the current inputs and slot contents. Software writes and reads the slots through a simple byte-addressed register port.

Top module: `prio_resolver`

## Requirements
- R1: After reset every slot reads zero (invalid) and the status word is 0x003F003F.
- R2: A slot takes part only when its valid bit (bit 31) is 1 and its source ID (bits 5:0) is below 40. A slot that fails either test is skipped.
- R3: A slot write keeps only bit 31 and bits 5:0, so the stored value is wdata & 0x8000003F. A read of the slot returns that stored value.
- R4: A source qualifies only when both pend[id] and enab[id] are 1. fiqsel[id]=1 sends it to the FIQ result and fiqsel[id]=0 sends it to the IRQ result.
- R5: When several slots qualify for the same class, the slot with the lowest index wins.
- R6: Layout of the status word: bit 31 is IRQ valid, bits 21:16 are the IRQ winner ID, bit 15 is FIQ valid and bits 5:0 are the FIQ winner ID. The two classes resolve independently.
- R7: A class with no qualifying slot reports valid 0 and ID 0x3F. Bits 30:22 and 14:6 are always 0.
- R8: Slot i is at byte offset 0x1C+4*i for i in 0..31, and at 0xB0+4*(i-32) for i in 32..39. Any other offset, including a misaligned one, reads 0 and ignores writes.
- R9: The status word follows changes of pend, enab and fiqsel in the same cycle, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pend | input | 40 | Pending flag per source |
| enab | input | 40 | Enable flag per source |
| fiqsel | input | 40 | Class select per source: 1 = FIQ, 0 = IRQ |
| wr_en | input | 1 | Slot write strobe |
| addr | input | 8 | Byte offset for the register port |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr (combinational) |
| hp_word | output | 32 | Packed highest-priority status word |

## Verification
A corrupted slot shows up in two places. It appears on rdata at its offset as soon as the address is applied. It also appears on hp_word in the same cycle that a source it names becomes pending and enabled. If the scan direction is wrong, the wrong winner appears as soon as two qualifying slots exist at once. A wrong range or valid test lets a forbidden ID, or a disabled slot, appear directly in the ID fields.

// File: rtl/prio_resolver.sv
module prio_resolver #(
  parameter int NSRC    = 40,
  parameter int NSLOT   = 40,
  parameter int ID_W    = 6,
  parameter int ADDR_W  = 8,
  parameter int LO_BASE = 'h1C,
  parameter int HI_BASE = 'hB0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   pend,
  input  logic [NSRC-1:0]   enab,
  input  logic [NSRC-1:0]   fiqsel,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic [31:0]       hp_word
);
  localparam int LO_CNT = 32;
  localparam int HI_CNT = NSLOT - LO_CNT;
  localparam int LO_END = LO_BASE + 4 * LO_CNT;
  localparam int HI_END = HI_BASE + 4 * HI_CNT;
  localparam int SEL_W  = $clog2(NSLOT);
  localparam logic [ID_W-1:0] NONE_ID = '1;

  logic            slot_v  [NSLOT];
  logic [ID_W-1:0] slot_id [NSLOT];

  logic             hit;
  logic [SEL_W-1:0] sel;

  always_comb begin
    hit = 1'b0;
    sel = '0;
    if (addr[1:0] == 2'b00) begin
      if (int'(addr) >= LO_BASE && int'(addr) < LO_END) begin
        hit = 1'b1;
        sel = SEL_W'((int'(addr) - LO_BASE) >> 2);
      end else if (int'(addr) >= HI_BASE && int'(addr) < HI_END) begin
        hit = 1'b1;
        sel = SEL_W'(LO_CNT + ((int'(addr) - HI_BASE) >> 2));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSLOT; i++) begin
        slot_v[i]  <= 1'b0;
        slot_id[i] <= '0;
      end
    end else if (wr_en && hit) begin
      slot_v[sel]  <= wdata[31];
      slot_id[sel] <= wdata[ID_W-1:0];
    end
  end

  assign rdata = hit ? {slot_v[sel], {(31-ID_W){1'b0}}, slot_id[sel]} : 32'h0;

  logic            fiq_ok, irq_ok;
  logic [ID_W-1:0] fiq_id, irq_id;

  always_comb begin
    fiq_ok = 1'b0;
    irq_ok = 1'b0;
    fiq_id = NONE_ID;
    irq_id = NONE_ID;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (slot_v[i] && int'(slot_id[i]) < NSRC) begin
        if (pend[slot_id[i]] && enab[slot_id[i]]) begin
          if (fiqsel[slot_id[i]]) begin
            fiq_ok = 1'b1;
            fiq_id = slot_id[i];
          end else begin
            irq_ok = 1'b1;
            irq_id = slot_id[i];
          end
        end
      end
    end
  end

  assign hp_word = {irq_ok, {(15-ID_W){1'b0}}, irq_id, fiq_ok, {(15-ID_W){1'b0}}, fiq_id};

  AST_FIQ_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    hp_word[15] |-> (int'(hp_word[5:0]) < NSRC) && pend[hp_word[5:0]] && enab[hp_word[5:0]] && fiqsel[hp_word[5:0]]); // R4
  AST_IRQ_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    hp_word[31] |-> (int'(hp_word[21:16]) < NSRC) && pend[hp_word[21:16]] && enab[hp_word[21:16]] && !fiqsel[hp_word[21:16]]); // R2
  AST_SENTINEL: assert property (@(posedge clk) disable iff (!rst_n)
    (!hp_word[15] |-> hp_word[5:0] == NONE_ID) and (!hp_word[31] |-> hp_word[21:16] == NONE_ID)); // R7
  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    hp_word[30:22] == '0 && hp_word[14:6] == '0); // R6
  AST_WRITE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit) |=> slot_v[$past(sel)] == $past(wdata[31]) && slot_id[$past(sel)] == $past(wdata[ID_W-1:0])); // R3
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> rdata == 32'h0); // R8
endmodule

// File: tb/prio_resolver_tb.sv
module prio_resolver_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [39:0] pend = '0, enab = '0, fiqsel = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, hp_word;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  prio_resolver u_dut (.clk(clk), .rst_n(rst_n), .pend(pend), .enab(enab), .fiqsel(fiqsel),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .hp_word(hp_word));

  function automatic logic [7:0] off_of(int i);
    return (i < 32) ? 8'(8'h1C + 4 * i) : 8'(8'hB0 + 4 * (i - 32));
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_check(string req, logic [7:0] a, logic [31:0] exp);
    addr = a;
    #1;
    check(req, rdata, exp);
  endtask

  task automatic word_check(string req, logic [31:0] exp);
    #1;
    check(req, hp_word, exp);
  endtask

  task automatic clear_all();
    for (int i = 0; i < 40; i++) wr(off_of(i), 32'h0);
    pend = '0; enab = '0; fiqsel = '0;
  endtask

  task automatic t_reset();
    word_check("R1 reset word", 32'h003F003F);
    rd_check("R1 slot0 reset", off_of(0), 32'h0);
    rd_check("R1 slot39 reset", off_of(39), 32'h0);
  endtask

  task automatic t_mask_map();
    wr(8'h1C, 32'hFFFFFFFF);
    rd_check("R3 mask slot0", 8'h1C, 32'h8000003F);
    wr(8'hCC, 32'h7FFFFFC5);
    rd_check("R3 mask slot39", 8'hCC, 32'h00000005);
    wr(8'hB0, 32'h80000011);
    rd_check("R8 slot32 offset", 8'hB0, 32'h80000011);
    rd_check("R8 slot31 untouched", 8'h98, 32'h0);
    wr(8'h14, 32'h8000000A);
    rd_check("R8 unmapped read zero", 8'h14, 32'h0);
    wr(8'h1D, 32'h8000000A);
    rd_check("R8 misaligned ignored", 8'h1C, 32'h8000003F);
    rd_check("R8 misaligned read zero", 8'h1D, 32'h0);
    clear_all();
  endtask

  task automatic t_basic();
    wr(off_of(0), 32'h80000003);
    wr(off_of(1), 32'h80000023);
    pend[3] = 1; pend[35] = 1; enab[3] = 1; enab[35] = 1; fiqsel[3] = 1;
    word_check("R6 both classes", 32'h80238003);
    enab[3] = 0;
    word_check("R9 R4 disable fiq source same cycle", 32'h8023003F);
    enab[35] = 0;
    word_check("R4 pending not enabled", 32'h003F003F);
    enab[35] = 1; pend[35] = 0;
    word_check("R4 enabled not pending", 32'h003F003F);
    clear_all();
  endtask

  task automatic t_prio();
    wr(off_of(5), 32'h80000009);
    wr(off_of(2), 32'h80000007);
    pend[7] = 1; pend[9] = 1; enab[7] = 1; enab[9] = 1;
    word_check("R5 lower slot wins", 32'h8007003F);
    pend[7] = 0;
    word_check("R5 next slot wins", 32'h8009003F);
    fiqsel[7] = 1; fiqsel[9] = 1; pend[7] = 1;
    word_check("R5 fiq lower slot wins", 32'h003F8007);
    clear_all();
  endtask

  task automatic t_valid();
    wr(off_of(0), 32'h80000032);
    wr(off_of(1), 32'h00000014);
    wr(off_of(3), 32'h8000000C);
    pend = '1; enab = '1; fiqsel = '0;
    word_check("R2 out-of-range and invalid skipped", 32'h800C003F);
    clear_all();
    wr(off_of(39), 32'h80000027);
    pend[39] = 1; enab[39] = 1; fiqsel[39] = 1;
    word_check("R2 R7 last slot id 39", 32'h003F8027);
    clear_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mask_map();
    t_basic();
    t_prio();
    t_valid();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual timeout expected completion");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule